// File: doc/BRIEF.md
# Four-Way Set-Associative Word Cache with Per-Set Round-Robin Refill

This block is a small set-associative cache holding 16 sets of 4 ways, each way a valid flag, a 24-bit tag and a line of four 32-bit words. A requester raises a strobe with a read/write type bit, a 32-bit word-aligned address and 32-bit write data. The hit flag and read data come back combinationally in that same cycle, and any change to storage commits on the next rising clock edge.

No backing memory is attached. On a miss, the cache picks a victim way in the addressed set and refills it locally. The refilled line is all zeros, except that a write miss places the write data in the addressed word. Each set keeps its own round-robin victim pointer, which steps only when that set misses.

Top module: `cache_sa_rr`

## Requirements
- R1: While `req_valid` is 0, `resp_hit` and `resp_rdata` are both 0, and no line and no victim pointer changes, whatever the other inputs carry.
- R2: A read (`req_write`=0) whose tag matches a valid way of the addressed set drives `resp_hit`=1 and puts the addressed word of that line on `resp_rdata`.
- R3: A write (`req_write`=1) that hits drives `resp_hit`=1 and `resp_rdata`=0, and it replaces only the addressed word of the hitting line. The other three words keep their values.
- R4: A read miss drives `resp_hit`=0 and `resp_rdata`=0. At the next edge the victim way becomes valid, with the request's tag and all four words zero.
- R5: A write miss drives both outputs to 0. At the next edge the victim way becomes valid, with the request's tag, the write data in the addressed word and zero in the other three words.
- R6: The victim pointer of a set cycles through ways 0, 1, 2, 3 and back to 0. It advances only on a miss in its own set. Hits, idle cycles and misses in other sets leave it unchanged.
- R7: Address fields are tag = `req_addr[31:8]`, set = `req_addr[7:4]` and word = `req_addr[3:2]`, with word 0 in the least significant 32 bits of the line. `req_addr[1:0]` has no effect.
- R8: Synchronous active-high reset clears every valid flag and sets every victim pointer to way 0. The first access to any address after reset therefore misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the accessed word |
| req_wdata | input | 32 | Write data |
| resp_hit | output | 1 | Request hit a valid line |
| resp_rdata | output | 32 | Read data on a read hit, otherwise 0 |

## Verification
Directed sequences come first. They check that the first access after reset misses, and that a write miss to a word other than word 0 leaves zeros in its neighbours. They also check that a write hit touches only its own word, and that an idle cycle carrying write data changes nothing. After filling one set past its four ways, a later read shows which tag was evicted, which separates correct round-robin order from a pointer that stays put, a pointer shared between sets, or a pointer that also steps on hits. A long random run follows, with a narrow pool of tags, random sets and words, and junk in the low address bits. The narrow pool keeps hits, misses and evictions interleaved, and every response is compared against a reference model in the bench.

// File: rtl/cache_rr_pkg.sv
`timescale 1ns/1ps
package cache_rr_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int NUM_SETS   = 16;
    localparam int NUM_WAYS   = 4;
    localparam int LINE_WORDS = 4;

    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int BSEL_W = $clog2(WORD_W / BYTE_W);
    localparam int OFF_W  = WSEL_W + BSEL_W;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    typedef logic [WORD_W-1:0]                   word_t;
    typedef logic [LINE_WORDS-1:0][WORD_W-1:0]   line_data_t;

    // Fields pulled out of a request address
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set_idx;
        logic [WSEL_W-1:0] word_sel;
    } req_fields_t;

    // One way of one set
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        line_data_t       data;
    } way_entry_t;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_RD_HIT = 2'd1,
        OP_WR_HIT = 2'd2,
        OP_FILL   = 2'd3
    } cache_op_e;

    function automatic req_fields_t split_addr(input logic [ADDR_W-1:0] a);
        req_fields_t f;
        f.tag      = a[ADDR_W-1 -: TAG_W];
        f.set_idx  = a[OFF_W +: SET_W];
        f.word_sel = a[BSEL_W +: WSEL_W];
        return f;
    endfunction

    function automatic line_data_t put_word(input line_data_t d,
                                            input logic [WSEL_W-1:0] sel,
                                            input word_t w);
        line_data_t r;
        r      = d;
        r[sel] = w;
        return r;
    endfunction

    function automatic logic [WAY_W-1:0] onehot_to_idx(input logic [NUM_WAYS-1:0] v);
        logic [WAY_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (v[i]) idx = idx | WAY_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/cache_line_store.sv
`timescale 1ns/1ps
module cache_line_store
    import cache_rr_pkg::*;
#(
    parameter int SETS = NUM_SETS,
    parameter int WAYS = NUM_WAYS,
    localparam int S_W = $clog2(SETS),
    localparam int W_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [S_W-1:0]             rd_set,
    output way_entry_t [WAYS-1:0]      rd_entries,
    input  logic                       wr_en,
    input  logic [S_W-1:0]             wr_set,
    input  logic [W_W-1:0]             wr_way,
    input  way_entry_t                 wr_entry
);

    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    line_data_t                data_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= wr_entry.valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_entry.tag;
            data_q[wr_set][wr_way] <= wr_entry.data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        always_comb begin
            rd_entries[w].valid = valid_q[rd_set][w];
            rd_entries[w].tag   = tag_q[rd_set][w];
            rd_entries[w].data  = data_q[rd_set][w];
        end
    end

endmodule

// File: rtl/cache_tag_match.sv
`timescale 1ns/1ps
module cache_tag_match
    import cache_rr_pkg::*;
#(
    parameter int WAYS = NUM_WAYS
) (
    input  way_entry_t [WAYS-1:0] entries,
    input  logic [TAG_W-1:0]      req_tag,
    output logic [WAYS-1:0]       hit_vec
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = entries[w].valid && (entries[w].tag == req_tag);
    end

endmodule

// File: rtl/cache_rr_ptr.sv
`timescale 1ns/1ps
module cache_rr_ptr #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int S_W = $clog2(SETS),
    localparam int W_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic [S_W-1:0]        adv_set,
    output logic [SETS*W_W-1:0]   ptr_flat
);

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [W_W-1:0] ptr_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
            end else if (adv && (adv_set == S_W'(s))) begin
                ptr_q <= (ptr_q == W_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
            end
        end

        assign ptr_flat[s*W_W +: W_W] = ptr_q;
    end

endmodule

// File: rtl/cache_sa_rr.sv
`timescale 1ns/1ps
module cache_sa_rr
    import cache_rr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        resp_hit,
    output logic [31:0] resp_rdata
);

    req_fields_t               fields;
    logic [SET_W-1:0]          req_set;
    way_entry_t [NUM_WAYS-1:0] set_entries;
    logic [NUM_WAYS-1:0]       hit_vec;
    logic                      hit_any;
    logic [WAY_W-1:0]          hit_way;
    logic [WAY_W-1:0]          victim_way;
    logic [NUM_SETS*WAY_W-1:0] rr_flat;
    cache_op_e                 op;
    way_entry_t                new_entry;
    logic [WAY_W-1:0]          upd_way;
    logic                      upd_en;
    line_data_t                base_data;

    assign fields  = split_addr(req_addr);
    assign req_set = fields.set_idx;

    cache_line_store #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_set     (req_set),
        .rd_entries (set_entries),
        .wr_en      (upd_en),
        .wr_set     (req_set),
        .wr_way     (upd_way),
        .wr_entry   (new_entry)
    );

    cache_tag_match #(.WAYS(NUM_WAYS)) u_match (
        .entries (set_entries),
        .req_tag (fields.tag),
        .hit_vec (hit_vec)
    );

    cache_rr_ptr #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_rr (
        .clk      (clk),
        .rst      (rst),
        .adv      (op == OP_FILL),
        .adv_set  (req_set),
        .ptr_flat (rr_flat)
    );

    assign hit_any    = |hit_vec;
    assign hit_way    = onehot_to_idx(hit_vec);
    assign victim_way = rr_flat[req_set*WAY_W +: WAY_W];

    always_comb begin
        if (!req_valid)    op = OP_IDLE;
        else if (!hit_any) op = OP_FILL;
        else if (req_write) op = OP_WR_HIT;
        else               op = OP_RD_HIT;
    end

    // Line to write: the hitting line or a zero line, with the written word merged in
    always_comb begin
        base_data       = (op == OP_FILL) ? '0 : set_entries[hit_way].data;
        new_entry.valid = 1'b1;
        new_entry.tag   = fields.tag;
        new_entry.data  = req_write ? put_word(base_data, fields.word_sel, req_wdata)
                                    : base_data;
    end

    assign upd_en  = (op == OP_FILL) || (op == OP_WR_HIT);
    assign upd_way = (op == OP_FILL) ? victim_way : hit_way;

    assign resp_hit   = (op == OP_RD_HIT) || (op == OP_WR_HIT);
    assign resp_rdata = (op == OP_RD_HIT) ? set_entries[hit_way].data[fields.word_sel] : '0;

endmodule

// File: rtl/cache_sa_rr_chk.sv
`timescale 1ns/1ps
module cache_sa_rr_chk
    import cache_rr_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic                      req_write,
    input logic                      resp_hit,
    input logic [31:0]               resp_rdata,
    input logic [NUM_WAYS-1:0]       hit_vec,
    input logic [SET_W-1:0]          req_set,
    input logic [NUM_SETS*WAY_W-1:0] rr_flat
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!resp_hit && resp_rdata == '0));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rr_flat));

    p_single_hit_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_hit_flag_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (resp_hit == (|hit_vec)));

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (resp_rdata == '0));

    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !resp_hit) |-> (resp_rdata == '0));

    p_rr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !resp_hit) |=>
        (rr_flat[$past(req_set)*WAY_W +: WAY_W] ==
         WAY_W'($past(rr_flat[req_set*WAY_W +: WAY_W]) + 1'b1)));

    p_hit_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && resp_hit) |=> $stable(rr_flat));

endmodule

bind cache_sa_rr cache_sa_rr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .resp_hit   (resp_hit),
    .resp_rdata (resp_rdata),
    .hit_vec    (hit_vec),
    .req_set    (req_set),
    .rr_flat    (rr_flat)
);

// File: tb/cache_sa_rr_tb.sv
`timescale 1ns/1ps
module cache_sa_rr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_hit;
    logic [31:0] resp_rdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Reference model state
    bit          m_valid [16][4];
    logic [23:0] m_tag   [16][4];
    logic [31:0] m_data  [16][4][4];
    int          m_ptr   [16];

    always #4 clk = ~clk;

    cache_sa_rr u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_hit   (resp_hit),
        .resp_rdata (resp_rdata)
    );

    task automatic model_reset();
        for (int s = 0; s < 16; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0;
                m_tag[s][w]   = '0;
                for (int k = 0; k < 4; k++) m_data[s][w][k] = '0;
            end
        end
    endtask

    // Predict the response and update the model per R1..R8
    task automatic model_access(input bit v, input bit wr, input logic [31:0] a,
                                input logic [31:0] d, output bit eh,
                                output logic [31:0] ed, output string lbl);
        logic [23:0] t;
        int s, k, hw;
        t  = a[31:8];
        s  = int'(a[7:4]);
        k  = int'(a[3:2]);
        hw = -1;
        eh = 1'b0;
        ed = '0;
        if (!v) begin
            lbl = "R1";
            return;
        end
        for (int w = 0; w < 4; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
        if (hw >= 0) begin
            eh = 1'b1;
            if (wr) begin
                m_data[s][hw][k] = d;
                lbl = "R3";
            end else begin
                ed  = m_data[s][hw][k];
                lbl = "R2";
            end
        end else begin
            int vw;
            vw = m_ptr[s];
            m_valid[s][vw] = 1'b1;
            m_tag[s][vw]   = t;
            for (int j = 0; j < 4; j++) m_data[s][vw][j] = '0;
            if (wr) m_data[s][vw][k] = d;
            m_ptr[s] = (vw + 1) % 4;
            lbl = wr ? "R5" : "R4";
        end
    endtask

    task automatic do_req(input bit v, input bit wr, input logic [31:0] a,
                          input logic [31:0] d, input string tag_lbl);
        bit          eh;
        logic [31:0] ed;
        string       lbl;
        @(negedge clk);
        req_valid = v;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        #2;
        model_access(v, wr, a, d, eh, ed, lbl);
        if (tag_lbl != "") lbl = tag_lbl;
        checks++;
        if (resp_hit !== eh || resp_rdata !== ed) begin
            failures++;
            $display("FAIL %s addr=%h wr=%0b v=%0b: got hit=%0b data=%h expected hit=%0b data=%h",
                     lbl, a, wr, v, resp_hit, resp_rdata, eh, ed);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd7151);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state gives idle zeros and a miss on first access
        do_req(1'b0, 1'b0, 32'h0000_0100, 32'h0, "R8");
        do_req(1'b1, 1'b0, 32'h0000_0100, 32'h0, "R8");
        do_req(1'b1, 1'b0, 32'h0000_0100, 32'h0, "R4");

        // R5: write miss to word 2 of set 3, neighbours zero
        do_req(1'b1, 1'b1, 32'h0000_2238, 32'hA5A5_0F0F, "R5");
        do_req(1'b1, 1'b0, 32'h0000_2238, 32'h0, "R5");
        do_req(1'b1, 1'b0, 32'h0000_2230, 32'h0, "R5");
        do_req(1'b1, 1'b0, 32'h0000_223C, 32'h0, "R5");

        // R3: write hit changes only word 1
        do_req(1'b1, 1'b1, 32'h0000_2234, 32'h1234_5678, "R3");
        do_req(1'b1, 1'b0, 32'h0000_2234, 32'h0, "R3");
        do_req(1'b1, 1'b0, 32'h0000_2238, 32'h0, "R3");

        // R1: idle cycle carrying a write has no effect
        do_req(1'b0, 1'b1, 32'h0000_2238, 32'hFFFF_FFFF, "R1");
        do_req(1'b1, 1'b0, 32'h0000_2238, 32'h0, "R1");

        // R7: low two address bits ignored
        do_req(1'b1, 1'b0, 32'h0000_223B, 32'h0, "R7");
        do_req(1'b1, 1'b1, 32'h0000_2235, 32'hCAFE_0001, "R7");
        do_req(1'b1, 1'b0, 32'h0000_2234, 32'h0, "R7");

        // R6: fill set 3, miss in set 5 between, then evict in order
        do_req(1'b1, 1'b1, 32'h0000_2330, 32'h0000_0023, "R6");
        do_req(1'b1, 1'b1, 32'h0000_2350, 32'h0000_0055, "R6");
        do_req(1'b1, 1'b1, 32'h0000_2430, 32'h0000_0024, "R6");
        do_req(1'b1, 1'b1, 32'h0000_2530, 32'h0000_0025, "R6");
        do_req(1'b1, 1'b0, 32'h0000_2330, 32'h0, "R6");
        do_req(1'b1, 1'b1, 32'h0000_2630, 32'h0000_0026, "R6");
        do_req(1'b1, 1'b0, 32'h0000_2238, 32'h0, "R6");
        do_req(1'b1, 1'b0, 32'h0000_2430, 32'h0, "R6");
        do_req(1'b1, 1'b0, 32'h0000_2330, 32'h0, "R6");
        do_req(1'b1, 1'b0, 32'h0000_2350, 32'h0, "R6");

        // Random mix over a narrow tag pool
        for (int i = 0; i < 4000; i++) begin
            bit          v, wr;
            logic [31:0] a, d;
            v  = ($urandom % 10) != 0;
            wr = $urandom % 2;
            a  = {16'h0, 8'($urandom % 6), 4'($urandom), 2'($urandom), 2'($urandom)};
            d  = $urandom;
            do_req(v, wr, a, d, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule